// File: doc/BRIEF.md
# Window Hit Discriminator

This block sits behind a pair of threshold comparators on a pixel or channel front end. It turns their two digitised outputs into one count strobe per pulse whose peak falls inside an energy window.

The lower comparator input is high while a pulse is above the lower threshold. A rising level on it opens a candidate, and the falling level closes it. If the upper comparator input is seen high at any point while a candidate is open, the pulse was too large. The candidate is then dropped and a diagnostic veto strobe is raised. If no upper assertion is seen before the lower input falls, one hit strobe is emitted. Upper-comparator activity outside any candidate is ignored.

Both comparator inputs are asynchronous to the system clock. Each passes through a multi-flop synchroniser before its edges are detected. A synchronous enable lets the surrounding logic gate counting, for example during readout.

Top module: `window_hit_disc`

## Requirements
- R1: While reset is asserted, and in the first cycles after its release with both comparator inputs low, `hit_o` and `veto_o` are low and no candidate is open.
- R2: A strobe caused by a comparator level presented before rising clock edge k is high in the clock cycle that follows edge k+SYNC_STAGES. This is because each comparator input passes SYNC_STAGES flops before edge detection.
- R3: A low-to-high change of the synchronised lower input opens a candidate. The following high-to-low change, with the upper input low throughout, gives exactly one `hit_o` pulse one cycle wide.
- R4: Upper input high in any cycle while a candidate is open closes it and gives one `veto_o` pulse one cycle wide. The later fall of the lower input then gives no hit, and further upper assertions before the next lower rise give nothing.
- R5: If the upper input is already high in the cycle the lower input rises, the candidate is vetoed at once (one `veto_o` pulse) and is never opened.
- R6: Upper input activity while no candidate is open produces neither strobe.
- R7: When the lower input falls in the same cycle that the upper input is high, veto wins: `veto_o` pulses and `hit_o` stays low.
- R8: While `enable_i` is low (sampled directly, without a synchroniser), any open candidate is discarded and both strobes stay low. A lower-input fall after enable returns gives no hit for that discarded candidate.
- R9: `hit_o` and `veto_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enable_i | input | 1 | Synchronous counting enable, active high |
| lo_cmp_i | input | 1 | Lower-threshold comparator output, asynchronous |
| hi_cmp_i | input | 1 | Upper-threshold comparator output, asynchronous |
| hit_o | output | 1 | One-cycle strobe per in-window pulse |
| veto_o | output | 1 | One-cycle strobe per candidate rejected by the upper threshold |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This shifts every strobe one cycle later than default and shows that the latency tracks the parameter. The same setting puts the enable input, which is not synchronised, out of phase with the comparator path, so a disable that overlaps a synchronised edge is exercised. Directed sequences hit the single-cycle lower pulse, the coincident rise and fall cases, and veto-versus-hit priority. Seeded random comparator traffic with rare enable drops covers the interleavings between them.

// File: rtl/win_disc_pkg.sv
package win_disc_pkg;

  // Edge flags produced from one synchronised level.
  typedef struct packed {
    logic rise;
    logic fall;
  } lvl_edge_t;

  // Index of each comparator in the shared synchroniser vector.
  localparam int unsigned CMP_LO  = 0;
  localparam int unsigned CMP_HI  = 1;
  localparam int unsigned CMP_NUM = 2;

endpackage

// File: rtl/wd_sync.sv
// Multi-flop level synchroniser for a vector of independent bits.
module wd_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[LAST];

endmodule

// File: rtl/wd_edge.sv
// Rise/fall detector on a synchronised level.
module wd_edge
  import win_disc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  output lvl_edge_t edge_o
);

  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
    end
  end

  always_comb begin
    edge_o.rise = lvl_i & ~lvl_q;
    edge_o.fall = ~lvl_i & lvl_q;
  end

  // A rise can never repeat in the next cycle: the level has been recorded.
  assert_rise_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o.rise |=> !edge_o.rise);

endmodule

// File: rtl/wd_window.sv
// Candidate tracking: arm on lower rise, veto on upper, hit on lower fall.
module wd_window
  import win_disc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      enable_i,
  input  lvl_edge_t lo_edge_i,
  input  logic      hi_lvl_i,
  output logic      hit_o,
  output logic      veto_o
);

  logic armed_q, armed_d;
  logic hit_q, hit_d;
  logic veto_q, veto_d;

  always_comb begin
    armed_d = armed_q;
    hit_d   = 1'b0;
    veto_d  = 1'b0;
    if (!enable_i) begin
      armed_d = 1'b0;
    end else if (armed_q && hi_lvl_i) begin
      armed_d = 1'b0;
      veto_d  = 1'b1;
    end else if (armed_q && lo_edge_i.fall) begin
      armed_d = 1'b0;
      hit_d   = 1'b1;
    end else if (lo_edge_i.rise && hi_lvl_i) begin
      veto_d  = 1'b1;
    end else if (lo_edge_i.rise) begin
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      hit_q   <= 1'b0;
      veto_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      hit_q   <= hit_d;
      veto_q  <= veto_d;
    end
  end

  assign hit_o  = hit_q;
  assign veto_o = veto_q;

  assert_no_overlap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_q && veto_q));

  assert_hit_from_armed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q |-> ($past(armed_q) && !armed_q));

  assert_veto_has_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    veto_q |-> $past(armed_q || lo_edge_i.rise));

  assert_disable_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!hit_q && !veto_q && !armed_q));

  assert_veto_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (veto_q && !armed_q) |=> !veto_q || $past(lo_edge_i.rise));

endmodule

// File: rtl/window_hit_disc.sv
// Double-threshold window hit discriminator, top level.
module window_hit_disc
  import win_disc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic lo_cmp_i,
  input  logic hi_cmp_i,
  output logic hit_o,
  output logic veto_o
);

  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_n_int;
  logic [CMP_NUM-1:0]    cmp_raw;
  logic [CMP_NUM-1:0]    cmp_sync;
  lvl_edge_t             lo_edge;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[RST_STAGES-1];

  always_comb begin
    cmp_raw         = '0;
    cmp_raw[CMP_LO] = lo_cmp_i;
    cmp_raw[CMP_HI] = hi_cmp_i;
  end

  wd_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (CMP_NUM)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .d_i    (cmp_raw),
    .q_o    (cmp_sync)
  );

  wd_edge u_lo_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .lvl_i  (cmp_sync[CMP_LO]),
    .edge_o (lo_edge)
  );

  wd_window u_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .enable_i  (enable_i),
    .lo_edge_i (lo_edge),
    .hi_lvl_i  (cmp_sync[CMP_HI]),
    .hit_o     (hit_o),
    .veto_o    (veto_o)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_n_int |=> (!hit_o && !veto_o));

endmodule

// File: tb/sim_window_hit_disc.sv
module sim_window_hit_disc;

  localparam int unsigned D    = 3;
  localparam int unsigned HLEN = D + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic lo = 1'b0;
  logic hi = 1'b0;
  logic hit, veto;

  int n_chk = 0;
  int n_err = 0;
  int n_hits = 0;
  int n_vetos = 0;

  logic  lo_h [HLEN];
  logic  hi_h [HLEN];
  logic  en_h [HLEN];
  string tag_h [HLEN];
  logic  m_armed = 1'b0;

  always #2.5 clk = ~clk;

  window_hit_disc #(.SYNC_STAGES(D)) u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .enable_i (en),
    .lo_cmp_i (lo),
    .hi_cmp_i (hi),
    .hit_o    (hit),
    .veto_o   (veto)
  );

  // Reference from the requirements: returns {armed_next, hit, veto}.
  function automatic logic [2:0] ref_step(input logic armed, input logic l,
                                          input logic lp, input logic h,
                                          input logic e);
    logic r, f;
    r = l & ~lp;
    f = ~l & lp;
    if (!e)               return 3'b000;  // R8
    if (armed && h)       return 3'b001;  // R4
    if (armed && f)       return 3'b010;  // R3
    if (r && h)           return 3'b001;  // R5
    if (r)                return 3'b100;  // R3
    return {armed, 2'b00};               // R6
  endfunction

  task automatic check(input logic act, input logic exp, input string what,
                       input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Sample at the falling edge, then drive the next inputs.
  task automatic step(input logic l, input logic h, input logic e, input string tag);
    logic [2:0] r;
    @(negedge clk);
    r = ref_step(m_armed, lo_h[D], lo_h[D+1], hi_h[D], en_h[0]);
    m_armed = r[2];
    check(hit,  r[1], "hit_o",  tag_h[D]);
    check(veto, r[0], "veto_o", tag_h[D]);
    n_chk++;
    if (hit && veto) begin
      n_err++;
      $display("FAIL R9 overlap: actual=11 expected=not both at %0t", $time);
    end
    if (hit)  n_hits++;
    if (veto) n_vetos++;
    for (int i = HLEN - 1; i > 0; i--) begin
      lo_h[i]  = lo_h[i-1];
      hi_h[i]  = hi_h[i-1];
      en_h[i]  = en_h[i-1];
      tag_h[i] = tag_h[i-1];
    end
    lo_h[0] = l; hi_h[0] = h; en_h[0] = e; tag_h[0] = tag;
    lo = l; hi = h; en = e;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1, tag);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic l, h, e;
    for (int i = 0; i < HLEN; i++) begin
      lo_h[i] = 1'b0; hi_h[i] = 1'b0; en_h[i] = 1'b0; tag_h[i] = "R1";
    end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: outputs low while in reset
    n_chk++;
    if (hit !== 1'b0 || veto !== 1'b0) begin
      n_err++;
      $display("FAIL R1 reset: actual=%0b%0b expected=00", hit, veto);
    end
    rst_n = 1'b1;
    idle(8, "R1");

    // R3: clean in-window pulse
    repeat (4) step(1'b1, 1'b0, 1'b1, "R3");
    idle(8, "R3");
    // R2: single-cycle lower pulse, latency checked by the reference timing
    step(1'b1, 1'b0, 1'b1, "R2");
    idle(8, "R2");
    // R4: upper asserted mid-candidate, twice, then lower falls
    repeat (2) step(1'b1, 1'b0, 1'b1, "R4");
    repeat (2) step(1'b1, 1'b1, 1'b1, "R4");
    step(1'b1, 1'b0, 1'b1, "R4");
    step(1'b1, 1'b1, 1'b1, "R4");
    step(1'b1, 1'b0, 1'b1, "R4");
    idle(8, "R4");
    // R5: both rise together
    repeat (3) step(1'b1, 1'b1, 1'b1, "R5");
    idle(8, "R5");
    // R6: upper alone
    repeat (3) step(1'b0, 1'b1, 1'b1, "R6");
    idle(8, "R6");
    // R7: lower falls while upper rises
    repeat (3) step(1'b1, 1'b0, 1'b1, "R7");
    step(1'b0, 1'b1, 1'b1, "R7");
    idle(8, "R7");
    // R8: disable during candidate, fall after re-enable
    repeat (2) step(1'b1, 1'b0, 1'b1, "R8");
    repeat (2) step(1'b1, 1'b0, 1'b0, "R8");
    repeat (D + 2) step(1'b1, 1'b0, 1'b1, "R8");
    idle(8, "R8");
    // R8: disable held across a full in-window pulse
    for (int i = 0; i < 10; i++) step(i > 1 && i < 5, 1'b0, 1'b0, "R8");
    idle(8, "R8");

    // Random traffic covering R3 R4 R5 R7 R8 interleavings
    l = 1'b0; h = 1'b0; e = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(5) == 0) l = ~l;
      if ($urandom_range(9) == 0) h = ~h;
      e = ($urandom_range(39) != 0);
      step(l, h, e, "R3_R4_R7_R8_random");
    end
    idle(10, "R1");
    n_chk++;
    if (n_hits == 0 || n_vetos == 0) begin
      n_err++;
      $display("FAIL R3 R4 coverage: actual hits=%0d vetos=%0d expected both>0", n_hits, n_vetos);
    end
    summary();
  end

endmodule